// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the host side of a three-wire serial EEPROM that holds 16-bit words. It turns single commands into serial frames on a chip-select, serial-clock and data-out line, and it collects read data or polls the program status on the return data line. The serial clock comes from the system clock through a divider. Every command is one beat on a valid/ready command port. Each beat gives back exactly one response pulse carrying read data and a timeout flag.

Each frame is padded with leading zero bits to a 16-bit boundary, so the host always clocks 16 or 32 bits. Program-type commands (word write, word erase, fill all, clear all) need the memory to be unlocked first. The controller keeps its own copy of the unlock state. When that copy is clear, it sends an unlock frame by itself before the program frame. After a program frame it drops chip select, raises it again and holds the data line low. It then watches the return line until the memory reports ready, or until a timeout expires.

The command port follows a valid/ready rule: a beat is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the engine is idle. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the requester must take `rsp_rdata` and `rsp_timeout` in that cycle.

Top module: `mw_host`

## Requirements
- R1: After reset release, `ee_cs` stays low and `cmd_ready` stays low for PWRUP clock cycles. `cmd_ready` rises within three cycles after that.
- R2: `ee_sk` is low whenever `ee_cs` is low. Each serial bit is DIV cycles with `ee_sk` low followed by DIV cycles with it high. `ee_di` changes only while `ee_sk` is low.
- R3: Every frame begins with 13-AW zero bits, then a 1 start bit, a 2-bit opcode and an AW-bit address field, all MSB first. The opcodes are read 10, write 01 and erase 11. All other commands use opcode 00 and set the two top address-field bits to 01 for fill, 10 for clear, 11 for unlock and 00 for lock; the remaining field bits are 0.
- R4: A read clocks 32 bits. The 16 `ee_do` values sampled at the end of the high phases of the last 16 bits are returned MSB first on `rsp_rdata` with the `rsp_valid` pulse.
- R5: Write and fill frames carry the 16 bits of `cmd_wdata` right after the address field, MSB first, for 32 bits in total.
- R6: An internal unlock flag is clear after reset, set by an unlock frame and cleared by a lock command. A program-type command that finds the flag clear is preceded by exactly one automatic unlock frame. When the flag is set, no unlock frame is sent.
- R7: Between any two frames, and between a program frame and its status poll, `ee_cs` stays low for at least TCSL cycles.
- R8: After a program frame the controller raises `ee_cs` to poll. During the poll `ee_di` and `ee_sk` stay low. The first high `ee_do` ends the poll with `rsp_timeout` = 0.
- R9: If `ee_do` stays low for TOUT cycles of polling, the controller drops `ee_cs` and returns `rsp_valid` with `rsp_timeout` = 1.
- R10: `cmd_op` codes are 0 read, 1 write, 2 erase, 3 fill, 4 clear, 5 unlock, 6 lock; code 7 acts as lock. `cmd_ready` is high only in idle with `ee_cs` low. Each accepted command yields one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command beat offered |
| cmd_ready | output | 1 | Engine idle, beat accepted this edge if valid |
| cmd_op | input | 3 | Command code (see R10) |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | 16 | Word for write and fill |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, valid with rsp_valid |
| rsp_timeout | output | 1 | Status poll expired, valid with rsp_valid |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
Several properties are checked on every cycle: the clock stays parked while chip select is low, the data line moves only with the clock low, and the line stays quiet during polling. They also cover the power-up hold-off, the chip-select low gap, the response pulse width and the origin of timeout responses. Some behaviour can only be shown by the bench's scenarios against its memory model and reference array. This covers whether frames decode to the intended opcode, address and data, and whether read data comes back bit-aligned. It also covers whether automatic unlock frames appear exactly when needed, and whether a memory that never reports ready produces a timeout response.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ERASE  = 3'd2,
    OP_FILL   = 3'd3,
    OP_CLEAR  = 3'd4,
    OP_UNLOCK = 3'd5,
    OP_LOCK   = 3'd6,
    OP_LOCK2  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_EN, S_ENGAP, S_MAIN, S_PGAP, S_POLL, S_REST
  } st_e;

  function automatic logic is_prog(op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_FILL) || (op == OP_CLEAR);
  endfunction
endpackage

// File: rtl/mw_countdown.sv
module mw_countdown #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(INIT);
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // a load in flight masks the stale zero
  assign expired = (cnt == '0) && !load;
endmodule

// File: rtl/mw_bit_engine.sv
module mw_bit_engine #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  nbits,
  input  logic [31:0] frame,
  input  logic        sdi,
  output logic        sck,
  output logic        sdo,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] ph;
  logic [31:0]   sh;
  logic [5:0]    left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; sh <= '0; left <= '0; sck <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; sh <= frame; left <= nbits; ph <= '0; sck <= 1'b0;
      end else if (busy) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            rx  <= {rx[14:0], sdi};
            sck <= 1'b0;
            if (left == 6'd1) begin
              busy <= 1'b0; done <= 1'b1;
            end else begin
              left <= left - 1'b1;
              sh   <= {sh[30:0], 1'b0};
            end
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign sdo = busy & sh[31];
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DIV   = 4,
  parameter int PWRUP = 1000000,
  parameter int TCSL  = 10,
  parameter int TOUT  = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [15:0]   cmd_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_timeout,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  localparam int TA   = (PWRUP > TOUT) ? PWRUP : TOUT;
  localparam int TMAX = (TA > TCSL) ? TA : TCSL;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [15:0] START_BIT = 16'(1) << (AW + 2);
  localparam logic [15:0] UNLOCK_HDR = START_BIT | (16'(2'b11) << (AW - 2));

  st_e           state;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic          wen_q, sel_en, eng_start, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp, eng_done, eng_busy;
  logic [15:0]   eng_rx;
  logic [1:0]    opc;
  logic [AW-1:0] fld;
  logic          long_f;
  logic [15:0]   hdr;
  logic [31:0]   eng_frame;
  logic [5:0]    eng_nbits;
  logic          polling;

  // frame assembly from the latched command
  always_comb begin
    opc = 2'b00; fld = addr_q; long_f = 1'b0;
    unique case (op_q)
      OP_READ:   begin opc = 2'b10; long_f = 1'b1; end
      OP_WRITE:  begin opc = 2'b01; long_f = 1'b1; end
      OP_ERASE:  opc = 2'b11;
      OP_FILL:   begin fld = AW'(2'b01) << (AW - 2); long_f = 1'b1; end
      OP_CLEAR:  fld = AW'(2'b10) << (AW - 2);
      OP_UNLOCK: fld = AW'(2'b11) << (AW - 2);
      default:   fld = '0;
    endcase
    hdr = START_BIT | (16'(opc) << AW) | 16'(fld);
    if (sel_en) begin
      eng_frame = {UNLOCK_HDR, 16'h0000};
      eng_nbits = 6'd16;
    end else begin
      eng_frame = {hdr, (op_q == OP_READ) ? 16'h0000 : data_q};
      eng_nbits = long_f ? 6'd32 : 6'd16;
    end
  end

  mw_bit_engine #(.DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .nbits(eng_nbits),
    .frame(eng_frame), .sdi(ee_do), .sck(ee_sk), .sdo(ee_di),
    .busy(eng_busy), .done(eng_done), .rx(eng_rx)
  );

  mw_countdown #(.W(TW), .INIT(PWRUP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_BOOT; op_q <= OP_READ; addr_q <= '0; data_q <= '0;
      wen_q <= 1'b0; sel_en <= 1'b0; eng_start <= 1'b0; tmr_load <= 1'b0;
      tmr_val <= '0; ee_cs <= 1'b0; rsp_valid <= 1'b0; rsp_rdata <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      tmr_load  <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state)
        S_BOOT: if (tmr_exp) state <= S_IDLE;
        S_IDLE: if (cmd_valid) begin
          op_q <= op_e'(cmd_op); addr_q <= cmd_addr; data_q <= cmd_wdata;
          sel_en    <= is_prog(op_e'(cmd_op)) && !wen_q;
          state     <= (is_prog(op_e'(cmd_op)) && !wen_q) ? S_EN : S_MAIN;
          ee_cs     <= 1'b1;
          eng_start <= 1'b1;
        end
        S_EN: if (eng_done) begin
          ee_cs <= 1'b0; wen_q <= 1'b1;
          tmr_load <= 1'b1; tmr_val <= TW'(TCSL); state <= S_ENGAP;
        end
        S_ENGAP: if (tmr_exp) begin
          ee_cs <= 1'b1; sel_en <= 1'b0; eng_start <= 1'b1; state <= S_MAIN;
        end
        S_MAIN: if (eng_done) begin
          ee_cs <= 1'b0; tmr_load <= 1'b1; tmr_val <= TW'(TCSL);
          if (is_prog(op_q)) begin
            state <= S_PGAP;
          end else begin
            rsp_valid <= 1'b1; rsp_timeout <= 1'b0; state <= S_REST;
            if (op_q == OP_READ) rsp_rdata <= eng_rx;
            wen_q <= (op_q == OP_UNLOCK) || ((op_q == OP_READ) && wen_q);
          end
        end
        S_PGAP: if (tmr_exp) begin
          ee_cs <= 1'b1; tmr_load <= 1'b1; tmr_val <= TW'(TOUT); state <= S_POLL;
        end
        S_POLL: if (ee_do || tmr_exp) begin
          ee_cs <= 1'b0; rsp_valid <= 1'b1; rsp_timeout <= !ee_do;
          tmr_load <= 1'b1; tmr_val <= TW'(TCSL); state <= S_REST;
        end
        S_REST: if (tmr_exp) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign polling   = (state == S_POLL);
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int PWRUP = 16,
  parameter int TCSL  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_timeout,
  input logic polling
);
  localparam int BW = $clog2(PWRUP + 1);
  localparam int LW = $clog2(TCSL + 1);
  logic [BW-1:0] boot_cnt;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_cnt <= '0; low_cnt <= '0;
    end else begin
      if (boot_cnt != BW'(PWRUP)) boot_cnt <= boot_cnt + 1'b1;
      if (ee_cs) low_cnt <= '0;
      else if (low_cnt != LW'(TCSL)) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> boot_cnt == BW'(PWRUP)); // R1
  AST_SK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk); // R2
  AST_DI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ee_di) |-> !ee_sk); // R2
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> low_cnt == LW'(TCSL)); // R7
  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    polling |-> !ee_di && !ee_sk); // R8
  AST_TIMEOUT_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> $past(polling)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ee_cs); // R10
endmodule

bind mw_host mw_host_chk #(.PWRUP(PWRUP), .TCSL(TCSL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
  .polling(polling)
);

// File: tb/mw_host_tb.sv
module mw_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int NW    = 1 << AW;
  localparam int DIV   = 2;
  localparam int PWRUP = 300;
  localparam int TCSL  = 6;
  localparam int TOUT  = 400;
  localparam int BUSY  = 60;
  localparam int PAD   = 13 - AW;
  localparam int WD    = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic ee_cs, ee_sk, ee_di, ee_do;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_host #(.AW(AW), .DIV(DIV), .PWRUP(PWRUP), .TCSL(TCSL), .TOUT(TOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [NW];

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 311) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] s_mem [NW];
  logic prev_cs = 1'b0, prev_sk = 1'b0, prev_di = 1'b0;
  logic s_started, s_read, s_rd, s_wen, s_verify, s_stuck = 1'b0;
  logic [31:0] s_sh;
  logic [1:0] s_op;
  logic [AW-1:0] s_a, s_rdaddr;
  int s_cnt, s_pad, s_rdbit, s_busy;
  int en_frames = 0, pad_err = 0, sk_err = 0, di_err = 0, hi_err = 0;
  int poll_di_err = 0, ign_err = 0, hi_len = 0, lo_len = 0, min_lo = 1000000;

  assign ee_do = (ee_cs && s_busy != 0) ? 1'b0 : (s_read ? s_rd : 1'b1);

  always @(negedge clk) begin
    if (!rst_n) begin
      s_started = 0; s_read = 0; s_rd = 0; s_wen = 0; s_verify = 0; s_busy = 0;
      s_cnt = 0; s_pad = 0; s_sh = '0; s_op = '0; s_a = '0; s_rdaddr = '0; s_rdbit = 15;
      for (int i = 0; i < NW; i++) s_mem[i] = init_word(i);
    end else begin
      if (s_busy != 0 && !s_stuck) s_busy--;
      if (ee_sk && !ee_cs) sk_err++;
      if (ee_di != prev_di && ee_sk && prev_sk) di_err++;
      if (ee_sk) hi_len++;
      if (!ee_sk && prev_sk) begin
        if (hi_len != DIV) hi_err++;
        hi_len = 0;
      end
      if (ee_cs && s_verify && ee_di) poll_di_err++;
      if (!ee_cs) lo_len++;
      if (ee_cs && !prev_cs) begin
        if (lo_len < min_lo) min_lo = lo_len;
        lo_len = 0;
      end
      if (ee_cs && ee_sk && !prev_sk) begin
        if (!s_started) begin
          if (ee_di) begin
            s_started = 1; s_cnt = 0; s_sh = '0;
            if (s_pad != PAD) pad_err++;
          end else s_pad++;
        end else begin
          if (s_read) begin
            s_rd = s_mem[s_rdaddr][s_rdbit];
            if (s_rdbit == 0) begin s_rdbit = 15; s_rdaddr++; end
            else s_rdbit--;
          end
          s_sh = {s_sh[30:0], ee_di};
          s_cnt++;
          if (s_cnt == AW + 2) begin
            s_op = s_sh[AW+1:AW]; s_a = s_sh[AW-1:0];
            if (s_op == 2'b10) begin s_read = 1; s_rd = 0; s_rdbit = 15; s_rdaddr = s_a; end
            if (s_op == 2'b00 && s_a[AW-1:AW-2] == 2'b11) begin s_wen = 1; en_frames++; end
            if (s_op == 2'b00 && s_a[AW-1:AW-2] == 2'b00) s_wen = 0;
          end
        end
      end
      if (!ee_cs && prev_cs) begin
        if (s_verify) s_verify = 0;
        else if (s_started) begin
          int kind;
          kind = 0;
          if (s_op == 2'b01 && s_cnt == AW + 18) kind = 1;
          else if (s_op == 2'b11 && s_cnt == AW + 2) kind = 2;
          else if (s_op == 2'b00 && s_a[AW-1:AW-2] == 2'b01 && s_cnt == AW + 18) kind = 3;
          else if (s_op == 2'b00 && s_a[AW-1:AW-2] == 2'b10 && s_cnt == AW + 2) kind = 4;
          if (kind != 0) begin
            if (!s_wen) ign_err++;
            else begin
              if (kind == 1) s_mem[s_a] = s_sh[15:0];
              if (kind == 2) s_mem[s_a] = 16'hFFFF;
              for (int i = 0; i < NW; i++) begin
                if (kind == 3) s_mem[i] = s_sh[15:0];
                if (kind == 4) s_mem[i] = 16'hFFFF;
              end
              s_busy = BUSY; s_verify = 1;
            end
          end
        end
      end
      if (!ee_cs) begin
        s_started = 0; s_read = 0; s_cnt = 0; s_pad = 0;
      end
      prev_cs = ee_cs; prev_sk = ee_sk; prev_di = ee_di;
    end
  end

  // ---------------- reference and command tasks ----------------
  task automatic ref_apply(input logic [2:0] op, input int addr, input logic [15:0] wd);
    case (op)
      3'd1: ref_mem[addr] = wd;
      3'd2: ref_mem[addr] = 16'hFFFF;
      3'd3: for (int i = 0; i < NW; i++) ref_mem[i] = wd;
      3'd4: for (int i = 0; i < NW; i++) ref_mem[i] = 16'hFFFF;
      default: ;
    endcase
  endtask

  task automatic run_cmd(input logic [2:0] op, input int addr, input logic [15:0] wd,
                         output logic [15:0] rd, output logic to);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10 ready drops after accept", 32'(cmd_ready), 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; to = rsp_timeout;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single-cycle response", 32'(rsp_valid), 0);
  endtask

  task automatic do_op(input logic [2:0] op, input int addr, input logic [15:0] wd, input string req);
    logic [15:0] rd;
    logic to;
    run_cmd(op, addr, wd, rd, to);
    if (op == 3'd0) chk(rd == ref_mem[addr], req, 32'(rd), 32'(ref_mem[addr]));
    else chk(to == 1'b0, req, 32'(to), 0);
    ref_apply(op, addr, wd);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    int unsigned r;
    logic [15:0] rd;
    logic to;
    for (int i = 0; i < NW; i++) ref_mem[i] = init_word(i);
    r = $urandom(32'd20231);
    repeat (4) @(negedge clk);
    chk(ee_cs == 0 && ee_sk == 0 && rsp_valid == 0 && cmd_ready == 0, "R1 reset state",
        {ee_cs, ee_sk, rsp_valid, cmd_ready}, 0);
    rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < PWRUP; k++) begin
      @(negedge clk);
      if (ee_cs || cmd_ready) bad++;
    end
    chk(bad == 0, "R1 quiet during power-up wait", bad, 0);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after power-up wait", 32'(cmd_ready), 1);

    do_op(3'd0, 5, 0, "R4 read word 5");
    do_op(3'd1, 9, 16'hBEEF, "R8 write completes without timeout");
    chk(en_frames == 1, "R6 one automatic unlock before first write", en_frames, 1);
    do_op(3'd0, 9, 0, "R5 read back written word");
    do_op(3'd1, 10, 16'h8001, "R5 write edge bits");
    chk(en_frames == 1, "R6 no unlock when already unlocked", en_frames, 1);
    do_op(3'd0, 10, 0, "R5 read back 8001");
    do_op(3'd6, 0, 0, "R10 lock command");
    do_op(3'd1, 11, 16'h0F0F, "R8 write after lock");
    chk(en_frames == 2, "R6 unlock reissued after lock", en_frames, 2);
    do_op(3'd0, 11, 0, "R6 write after lock landed");
    do_op(3'd2, 5, 0, "R3 erase completes");
    do_op(3'd0, 5, 0, "R3 erased word reads ones");
    do_op(3'd0, NW - 1, 0, "R4 read top address");
    do_op(3'd0, 0, 0, "R4 read address zero");
    do_op(3'd5, 0, 0, "R10 explicit unlock");
    chk(en_frames == 3, "R6 explicit unlock frame", en_frames, 3);

    for (int n = 0; n < 30; n++) begin
      logic [2:0] op;
      int a;
      r = $urandom;
      a = int'(r[13:8]);
      case (r % 7)
        0, 1, 2: op = 3'd0;
        3, 4:    op = 3'd1;
        5:       op = 3'd2;
        default: op = 3'd6;
      endcase
      do_op(op, a, r[31:16], (op == 3'd0) ? "R4 random read" : "R8 random command");
    end

    do_op(3'd3, 0, 16'h1234, "R5 fill completes");
    do_op(3'd0, 17, 0, "R5 fill word 17");
    do_op(3'd0, NW - 1, 0, "R5 fill top word");
    do_op(3'd4, 0, 0, "R3 clear completes");
    do_op(3'd0, 33, 0, "R3 clear word 33");

    s_stuck = 1'b1;
    run_cmd(3'd1, 3, 16'hCAFE, rd, to);
    ref_apply(3'd1, 3, 16'hCAFE);
    chk(to == 1'b1, "R9 stuck memory times out", 32'(to), 1);
    chk(ee_cs == 1'b0, "R9 chip select released", 32'(ee_cs), 0);
    s_stuck = 1'b0;
    repeat (BUSY + 20) @(negedge clk);
    do_op(3'd0, 3, 0, "R9 recovery read");

    chk(sk_err == 0, "R2 clock parked with select low", sk_err, 0);
    chk(di_err == 0, "R2 data moves only with clock low", di_err, 0);
    chk(hi_err == 0, "R2 high phase length", hi_err, 0);
    chk(pad_err == 0, "R3 leading zero padding", pad_err, 0);
    chk(min_lo >= TCSL, "R7 minimum select-low gap", min_lo, TCSL);
    chk(poll_di_err == 0, "R8 data low while polling", poll_di_err, 0);
    chk(ign_err == 0, "R6 no program while locked", ign_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule